// File: doc/BRIEF.md
# Dual-Clock Elastic I/Q Sample Buffer

This block moves 32-bit I/Q sample pairs from a source-synchronous write clock domain into a locally generated read clock domain. It sits between the input capture stage and the sample datapath. Its job is to absorb slow clock-to-data drift between the two clocks.

The buffer holds eight entries. Two pointers circle through those entries with a fixed, programmable gap between them. There is no full or empty handshake. Each pointer returns to its home position on a rising edge of its own sync source:
- The write pointer's home is address 0.
- The read pointer's home is a programmable offset.

The read side can take its sync from either of two sources. One is the write-side sync, re-captured through a two-flop synchronizer. The other is a separate strobe sampled directly by the read clock.

A collision detector compares the read address with the write pointer as seen in the read domain. A match raises a sticky error flag, which software clears with a pulse. A sample-valid output stays low until the read pointer has been homed once after reset.

Top module: `elastic_iq_buffer`

## Requirements
- R1: After reset the write pointer is at address 0 and the read pointer is at `home_ofs`. `rd_valid` and `collision` are 0.
- R2: When `wr_en` is 1 on a `wr_clk` rising edge, `{wr_i, wr_q}` is stored at the write address and the write pointer advances by one, wrapping from 7 to 0. When `wr_en` is 0 the write pointer holds.
- R3: When `rd_en` is 1 on a `rd_clk` rising edge, the entry at the read address appears on `{rd_i, rd_q}` after that edge and the read pointer advances by one, wrapping from 7 to 0. When `rd_en` is 0 the outputs and the read pointer hold.
- R4: `wr_sync` is sampled on `wr_clk` rising edges. In the edge where it is first seen high after being low, the write uses address 0 and the pointer continues from there. Holding it high does not re-trigger.
- R5: With `rd_src` = 1 (strobe source), the edge where `rd_strobe` is first seen high makes that read use `home_ofs`. The read pointer then continues from `home_ofs` + 1.
- R6: With `rd_src` = 0, `wr_sync` passes through two `rd_clk` flops and a rising-edge detector. The read that takes place on the following edge uses `home_ofs`.
- R7: A sync edge that arrives while a pointer is already at its home position leaves the sample sequence unchanged.
- R8: `rd_valid` is 0 until the first read-pointer home event after reset. After that it equals `rd_en` as registered at each read edge.
- R9: A read whose address equals the synchronized write pointer sets `collision`. The flag stays set until `clr_collision` is high on a read edge with no new match. A match in the same edge as the clear wins.
- R10: With equal clock rates and a constant gap between the pointers, each read returns exactly the sample that the gap predicts, in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write domain |
| wr_en | input | 1 | Store one sample on this edge |
| wr_i | input | 16 | In-phase half of the incoming sample |
| wr_q | input | 16 | Quadrature half of the incoming sample |
| wr_sync | input | 1 | Write-pointer sync; a rising edge re-homes to 0 |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read domain |
| rd_en | input | 1 | Read one sample on this edge |
| rd_src | input | 1 | Read-home source: 0 = synchronized `wr_sync`, 1 = `rd_strobe` |
| rd_strobe | input | 1 | Read-domain home strobe |
| home_ofs | input | 3 | Read-pointer home address |
| clr_collision | input | 1 | Clear pulse for the collision flag |
| rd_i | output | 16 | In-phase half of the sample read out |
| rd_q | output | 16 | Quadrature half of the sample read out |
| rd_valid | output | 1 | Read sample is valid (read side has been homed) |
| collision | output | 1 | Sticky pointer-collision flag |

## Verification
Two functions can fall in the same cycle:
- A re-home event and the pointer's natural wrap onto its home address.
- A collision match and a clear pulse.

The first case is provoked by waiting until the bench's own model pointer sits at home, then raising `wr_sync` or `rd_strobe`. It is judged by an unbroken, exactly predicted sample sequence. Mid-lap sync edges are also applied, to show that the jump does happen when the pointer is elsewhere.

The collision path is provoked by speeding the write clock until the pointers meet. The flag is then checked for persistence while reads are halted, and for its return to 0 after a clear.

// File: rtl/esf_pkg.sv
package esf_pkg;

    localparam int HALF_W = 16;
    localparam int DEPTH_DEFAULT = 8;

    typedef struct packed {
        logic [HALF_W-1:0] i;
        logic [HALF_W-1:0] q;
    } iq_t;

    typedef enum logic {
        SRC_WRSYNC = 1'b0,
        SRC_STROBE = 1'b1
    } rd_src_e;

    function automatic int unsigned bin2gray(input int unsigned b);
        return b ^ (b >> 1);
    endfunction

    function automatic int unsigned gray2bin(input int unsigned g);
        int unsigned b;
        b = g;
        for (int s = 1; s < 32; s = s * 2) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction

endpackage

// File: rtl/esf_sync2.sv
module esf_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/esf_store.sv
module esf_store
    import esf_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEFAULT,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  iq_t           wdata,
    input  logic [AW-1:0] raddr,
    output iq_t           rdata
);
    iq_t mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/esf_wr_side.sv
module esf_wr_side
    import esf_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          sync_in,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] gray
);
    logic          sync_q;
    logic [AW-1:0] wptr;
    logic [AW-1:0] addr_next;
    logic          rise;

    assign rise      = sync_in & ~sync_q;
    assign addr      = rise ? '0 : wptr;
    assign addr_next = addr + AW'(en);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 1'b0;
            wptr   <= '0;
            gray   <= '0;
        end else begin
            sync_q <= sync_in;
            wptr   <= addr_next;
            gray   <= AW'(bin2gray(32'(addr_next)));
        end
    end

    // R4: a fresh sync edge together with a write leaves the pointer just past home
    a_r4_rehome_write: assert property (@(posedge clk) disable iff (rst)
        (sync_in && !sync_q && en) |=> (wptr == AW'(1)));

    // R2: no write and no sync edge keeps the write pointer still
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!en && !(sync_in && !sync_q)) |=> $stable(wptr));
endmodule

// File: rtl/esf_rd_side.sv
module esf_rd_side
    import esf_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  rd_src_e       src,
    input  logic          strobe,
    input  logic          wsync_raw,
    input  logic [AW-1:0] wgray_raw,
    input  logic [AW-1:0] home,
    input  logic          clr,
    input  iq_t           mem_data,
    output logic [AW-1:0] addr,
    output iq_t           data,
    output logic          valid,
    output logic          coll
);
    logic          ws2, ws3, stq, seen;
    logic          evt_w, evt_s, evt, hit;
    logic [AW-1:0] wg2, wbin, rptr;

    esf_sync2 #(.W(1)) u_sync_evt (
        .clk(clk), .rst(rst), .d(wsync_raw), .q(ws2)
    );

    esf_sync2 #(.W(AW)) u_sync_ptr (
        .clk(clk), .rst(rst), .d(wgray_raw), .q(wg2)
    );

    assign wbin  = AW'(gray2bin(32'(wg2)));
    assign evt_w = ws2 & ~ws3;
    assign evt_s = strobe & ~stq;
    assign evt   = (src == SRC_STROBE) ? evt_s : evt_w;
    assign addr  = evt ? home : rptr;
    assign hit   = en && (addr == wbin);

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr  <= home;
            ws3   <= 1'b0;
            stq   <= 1'b0;
            seen  <= 1'b0;
            valid <= 1'b0;
            coll  <= 1'b0;
            data  <= '0;
        end else begin
            rptr  <= addr + AW'(en);
            ws3   <= ws2;
            stq   <= strobe;
            seen  <= seen | evt;
            valid <= en & (seen | evt);
            coll  <= hit | (coll & ~clr);
            if (en) begin
                data <= mem_data;
            end
        end
    end

    // R5: a fresh strobe edge with a read continues from home + 1
    a_r5_strobe_home: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_STROBE && strobe && !stq && en) |=> (rptr == AW'($past(home) + AW'(1))));

    // R8: valid output never precedes the first home event
    a_r8_valid_after_home: assert property (@(posedge clk) disable iff (rst)
        valid |-> seen);

    // R9: flag persists without a clear
    a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
        (coll && !clr) |=> coll);

    // R3: outputs hold while reads are paused
    a_r3_hold_data: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(data));
endmodule

// File: rtl/elastic_iq_buffer.sv
module elastic_iq_buffer
    import esf_pkg::*;
#(
    parameter int DEPTH = DEPTH_DEFAULT
) (
    input  logic                       wr_clk,
    input  logic                       wr_rst,
    input  logic                       wr_en,
    input  logic [HALF_W-1:0]          wr_i,
    input  logic [HALF_W-1:0]          wr_q,
    input  logic                       wr_sync,
    input  logic                       rd_clk,
    input  logic                       rd_rst,
    input  logic                       rd_en,
    input  logic                       rd_src,
    input  logic                       rd_strobe,
    input  logic [$clog2(DEPTH)-1:0]   home_ofs,
    input  logic                       clr_collision,
    output logic [HALF_W-1:0]          rd_i,
    output logic [HALF_W-1:0]          rd_q,
    output logic                       rd_valid,
    output logic                       collision
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] waddr, wgray, raddr;
    iq_t           wword, mem_q, rword;

    assign wword = '{i: wr_i, q: wr_q};

    esf_wr_side #(.AW(AW)) u_wr (
        .clk(wr_clk), .rst(wr_rst), .en(wr_en), .sync_in(wr_sync),
        .addr(waddr), .gray(wgray)
    );

    esf_store #(.DEPTH(DEPTH)) u_mem (
        .wr_clk(wr_clk), .we(wr_en), .waddr(waddr), .wdata(wword),
        .raddr(raddr), .rdata(mem_q)
    );

    esf_rd_side #(.AW(AW)) u_rd (
        .clk(rd_clk), .rst(rd_rst), .en(rd_en), .src(rd_src_e'(rd_src)),
        .strobe(rd_strobe), .wsync_raw(wr_sync), .wgray_raw(wgray),
        .home(home_ofs), .clr(clr_collision), .mem_data(mem_q),
        .addr(raddr), .data(rword), .valid(rd_valid), .coll(collision)
    );

    assign rd_i = rword.i;
    assign rd_q = rword.q;
endmodule

// File: tb/elastic_iq_buffer_test.sv
`timescale 1ns/100ps
module elastic_iq_buffer_test;
    logic        wr_clk = 1'b0, rd_clk = 1'b0;
    logic        wr_rst = 1'b1, rd_rst = 1'b1;
    logic        wr_en = 1'b0, wr_sync = 1'b0;
    logic [15:0] wr_i = '0, wr_q = '0;
    logic        rd_en = 1'b0, rd_src = 1'b1, rd_strobe = 1'b0, clr_collision = 1'b0;
    logic [2:0]  home_ofs = 3'd4;
    logic [15:0] rd_i, rd_q;
    logic        rd_valid, collision;

    int total = 0, bad = 0;
    int wr_half = 5;
    bit wr_go = 0;
    bit exact = 0;
    string cur_req = "R1";

    elastic_iq_buffer uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_i(wr_i), .wr_q(wr_q),
        .wr_sync(wr_sync), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
        .rd_src(rd_src), .rd_strobe(rd_strobe), .home_ofs(home_ofs),
        .clr_collision(clr_collision), .rd_i(rd_i), .rd_q(rd_q),
        .rd_valid(rd_valid), .collision(collision)
    );

    always #(wr_half) wr_clk = ~wr_clk;

    initial begin
        #2.5;
        forever begin
            int j;
            j = int'($urandom % 2);
            rd_clk = 1'b1; #5;
            rd_clk = 1'b0; #(5 + j);
            rd_clk = 1'b1; #5;
            rd_clk = 1'b0; #(5 - j);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---- reference model, built from the requirements ----
    logic [31:0] mem_m [8];
    bit          vld_m [8];
    int          wp_m = 0, rp_m = 4;
    bit          wprev = 0, seen_m = 0, stq_m = 0, s1m = 0, s2m = 0, s3m = 0;
    logic [31:0] exp_d;
    bit          exp_v = 0, ent_ok = 0, pend = 0;

    always @(posedge wr_clk) begin
        if (wr_rst) begin
            wp_m = 0; wprev = 0;
        end else begin
            int a;
            a = (wr_sync && !wprev) ? 0 : wp_m;
            if (wr_en) begin
                mem_m[a] = {wr_i, wr_q};
                vld_m[a] = 1;
            end
            wp_m  = (a + (wr_en ? 1 : 0)) % 8;
            wprev = wr_sync;
        end
    end

    always @(posedge rd_clk) begin
        if (rd_rst) begin
            rp_m = int'(home_ofs); seen_m = 0; stq_m = 0;
            s1m = 0; s2m = 0; s3m = 0; pend = 0;
        end else begin
            bit ev;
            int a;
            ev = rd_src ? (rd_strobe && !stq_m) : (s2m && !s3m);
            a  = ev ? int'(home_ofs) : rp_m;
            pend = rd_en;
            if (rd_en) begin
                exp_d  = mem_m[a];
                ent_ok = vld_m[a];
                exp_v  = seen_m || ev;
            end
            if (ev) seen_m = 1;
            rp_m  = (a + (rd_en ? 1 : 0)) % 8;
            stq_m = rd_strobe;
            s3m = s2m; s2m = s1m; s1m = wr_sync;
        end
    end

    always @(negedge rd_clk) begin
        if (exact && pend && !rd_rst) begin
            chk(cur_req, {31'b0, rd_valid}, {31'b0, exp_v});
            if (ent_ok) chk(cur_req, {rd_i, rd_q}, exp_d);
        end
    end

    // write-domain driver: random sample data
    always @(negedge wr_clk) begin
        wr_en = wr_go && !wr_rst;
        if (wr_go) {wr_i, wr_q} = $urandom;
    end

    task automatic rd_cyc(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic wsync_at(input int target);
        do @(negedge wr_clk); while (wp_m != target);
        wr_sync = 1'b1;
        repeat (3) @(negedge wr_clk);
        wr_sync = 1'b0;
    endtask

    task automatic strobe_at(input int target);
        do @(negedge rd_clk); while (rp_m != target);
        rd_strobe = 1'b1;
        rd_cyc(3);
        rd_strobe = 1'b0;
    endtask

    task automatic finish_up;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #3_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int k = 0; k < 8; k++) vld_m[k] = 0;
        rd_cyc(4);
        wr_rst = 1'b0; rd_rst = 1'b0;
        @(negedge rd_clk);
        // R1: outputs after reset
        chk("R1", {31'b0, rd_valid}, 32'd0);
        chk("R1", {31'b0, collision}, 32'd0);

        exact = 1;
        cur_req = "R8";            // reads before any home event: valid stays 0
        wr_go = 1; rd_en = 1'b1; rd_src = 1'b1;
        rd_cyc(12);

        cur_req = "R5";            // strobe source homes the read pointer
        strobe_at(1);
        rd_cyc(20);

        cur_req = "R4";            // mid-lap write sync, held high for 3 cycles
        wsync_at(3);
        rd_cyc(20);

        cur_req = "R7";            // sync edges exactly at natural wrap
        wsync_at(0);
        rd_cyc(10);
        strobe_at(4);
        rd_cyc(20);

        cur_req = "R2";            // random write pauses
        for (int k = 0; k < 40; k++) begin
            wr_go = ($urandom % 4) != 0;
            @(negedge rd_clk);
        end
        wr_go = 1;

        cur_req = "R3";            // random read pauses, then a directed hold
        for (int k = 0; k < 40; k++) begin
            rd_en = ($urandom % 4) != 0;
            @(negedge rd_clk);
        end
        rd_en = 1'b0;
        @(negedge rd_clk);
        begin
            logic [31:0] held;
            logic        hv;
            held = {rd_i, rd_q};
            hv   = rd_valid;
            rd_cyc(3);
            chk("R3", {rd_i, rd_q}, held);
            chk("R3", {31'b0, rd_valid}, {31'b0, hv});
        end
        rd_en = 1'b1;

        cur_req = "R10";           // re-home both, constant gap at a new offset
        home_ofs = 3'd3;
        fork
            wsync_at(2);
            strobe_at(6);
        join
        rd_cyc(60);

        cur_req = "R6";            // read home taken from synchronized write sync
        rd_src = 1'b0;
        home_ofs = 3'd4;
        wsync_at(5);
        rd_cyc(40);

        // R9: no false collision at a steady gap, after a clear
        clr_collision = 1'b1;
        @(negedge rd_clk);
        clr_collision = 1'b0;
        rd_cyc(40);
        chk("R9", {31'b0, collision}, 32'd0);

        // R9: faster write clock makes the pointers meet
        exact = 0;
        cur_req = "R9";
        wr_half = 3;
        rd_cyc(80);
        chk("R9", {31'b0, collision}, 32'd1);
        rd_en = 1'b0;
        wr_half = 5;
        rd_cyc(6);
        chk("R9", {31'b0, collision}, 32'd1);
        clr_collision = 1'b1;
        @(negedge rd_clk);
        clr_collision = 1'b0;
        chk("R9", {31'b0, collision}, 32'd0);

        finish_up();
    end
endmodule